// File: doc/BRIEF.md
# Instruction Length Decoder for 32-bit x86 Byte Streams

This block takes a stream of 32-bit x86 instruction bytes, one byte per valid/ready handshake, and finds where each instruction ends. For every instruction it gives a one-cycle result: the length in bytes, the stream offset of the first byte, and the offset where the next instruction begins. Front-end logic, trace tools and pre-decoders use it to split a raw byte stream at instruction boundaries.

It handles a small opcode set. The set has the two-byte escape, a few general ModR/M opcodes with full 32-bit memory addressing (SIB and displacement), one opcode with an 8-bit immediate, and the four moves to and from control and debug registers. Those system moves always take a register operand. Their mod field is ignored when counting length, so they never consume a SIB or displacement byte. The block also flags a privilege fault for these moves outside ring 0. When strict checking is enabled, it flags any such move whose mod field is not 11. Any other opcode is reported as undefined, so that the consumer can resynchronise.

Top module: `insn_len_decoder`

## Requirements
- R1: While rst_ni is low, done_o is 0 and byte_ready_o is 0. From the first clock edge after release, byte_ready_o is 1 and the first instruction is reported at offset 0.
- R2: The general opcodes are 01, 03, 89, 8B, 8D, and 0F AF after the escape. Each is followed by a ModR/M byte whose mod is bits 7-6 and whose rm is bits 2-0. Mod 11 adds no bytes, mod 01 adds 1 displacement byte, mod 10 adds 4, and mod 00 with rm 101 adds 4.
- R3: With mod not 11 and rm 100, one SIB byte follows the ModR/M byte. If the SIB base (bits 2-0) is 101 under mod 00, 4 displacement bytes follow. Otherwise mod 01 adds 1 byte after the SIB and mod 10 adds 4.
- R4: Opcode 83 carries one immediate byte after all its addressing bytes.
- R5: After the escape byte 0F, the second opcode byte AF is decoded with the R2/R3 rules, so lengths start at 3.
- R6: The moves 0F 20, 0F 21, 0F 22 and 0F 23 are always 3 bytes long, whatever their mod and rm. The byte after the ModR/M byte starts the next instruction, so 0F 20 53 FF gives a 3-byte move followed by an instruction that starts with FF.
- R7: bad_enc_o is 1 for a system move when strict_i is 1 and the ModR/M mod is not 11. It is 0 in every other case, and the length does not change.
- R8: gp_fault_o is 1 for a system move when cpl_i is nonzero, and 0 for every other instruction. strict_i and cpl_i are sampled when the ModR/M byte is accepted.
- R9: Any other opcode sets ud_o and ends the instruction at once. The length is 1 for a one-byte opcode and 2 for an unknown byte after 0F.
- R10: done_o is high for exactly one cycle, in the cycle after the last byte of an instruction is accepted. In that cycle len_o, start_o and next_o = start_o + len_o (modulo 2^OFF_W) are valid. Each instruction starts at the previous next_o.
- R11: A cycle with byte_valid_i low consumes no byte, leaves decoding where it stood, and produces no done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Instruction byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_ready_o | output | 1 | Decoder accepts a byte |
| strict_i | input | 1 | Enables the malformed-encoding check for system moves |
| cpl_i | input | 2 | Current privilege level |
| done_o | output | 1 | Result strobe, one cycle per instruction |
| len_o | output | LEN_W | Instruction length in bytes |
| start_o | output | OFF_W | Offset of the first byte |
| next_o | output | OFF_W | Offset of the next instruction |
| ud_o | output | 1 | Undefined opcode |
| gp_fault_o | output | 1 | Privilege fault on a system move |
| bad_enc_o | output | 1 | System move with mod other than 11 under strict checking |

## Verification
The bench builds the decoder with OFF_W = 8 and the default LEN_W = 4. With an 8-bit offset, a run of a few hundred bytes wraps the offset counter several times. That checks the next_o arithmetic and the chaining of start offsets across the wrap. LEN_W = 4 covers the longest supported form: opcode 83 with a SIB byte, a 4-byte displacement and an immediate, 8 bytes in all. Idle cycles in the middle of instructions and a reset in the middle of the run exercise the hold and restart behaviour.

// File: rtl/ild_pkg.sv
package ild_pkg;
  typedef enum logic [2:0] {
    ST_OP, ST_OP2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } ild_state_e;

  typedef enum logic [2:0] {
    CL_ESC, CL_GEN, CL_GEN_I8, CL_SYS, CL_UD
  } ild_class_e;

  localparam logic [7:0] OP_ESC = 8'h0F;
  localparam int unsigned MAX_LEN = 8;
endpackage

// File: rtl/ild_opc_class.sv
module ild_opc_class
  import ild_pkg::*;
(
  input  logic [7:0]  op_i,
  input  logic        esc_i,
  output ild_class_e  cls_o
);
  always_comb begin
    cls_o = CL_UD;
    if (esc_i) begin
      unique casez (op_i)
        8'b0010_00??: cls_o = CL_SYS;   // 20..23 register moves
        8'hAF:        cls_o = CL_GEN;
        default:      cls_o = CL_UD;
      endcase
    end else begin
      unique case (op_i)
        OP_ESC:                         cls_o = CL_ESC;
        8'h01, 8'h03, 8'h89, 8'h8B,
        8'h8D:                          cls_o = CL_GEN;
        8'h83:                          cls_o = CL_GEN_I8;
        default:                        cls_o = CL_UD;
      endcase
    end
  end
endmodule

// File: rtl/ild_addr_calc.sv
module ild_addr_calc (
  input  logic [7:0] byte_i,
  input  logic       is_sib_i,
  input  logic [1:0] mod_i,
  output logic       need_sib_o,
  output logic [2:0] disp_n_o
);
  logic [1:0] mod_eff;
  logic [2:0] low3;

  // SIB base and ModR/M rm share bits 2-0 and the same 101 special case
  assign mod_eff    = is_sib_i ? mod_i : byte_i[7:6];
  assign low3       = byte_i[2:0];
  assign need_sib_o = !is_sib_i && (mod_eff != 2'b11) && (low3 == 3'b100);

  always_comb begin
    unique case (mod_eff)
      2'b00:   disp_n_o = (low3 == 3'b101) ? 3'd4 : 3'd0;
      2'b01:   disp_n_o = 3'd1;
      2'b10:   disp_n_o = 3'd4;
      default: disp_n_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             strict_i,
  input  logic [1:0]       cpl_i,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic [OFF_W-1:0] start_o,
  output logic [OFF_W-1:0] next_o,
  output logic             ud_o,
  output logic             gp_fault_o,
  output logic             bad_enc_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  ild_state_e       state_q, state_d;
  ild_class_e       cls;
  logic [LEN_W-1:0] cnt_q;
  logic [OFF_W-1:0] base_q;
  logic [1:0]       mod_q, mod_d;
  logic [2:0]       disp_q, disp_d, disp_n;
  logic             sys_q, sys_d, imm_q, imm_d;
  logic             need_sib, ready_q, accept;
  logic             fin, fin_ud, fin_gp, fin_bad;
  logic [OFF_W-1:0] next_base;

  assign accept       = byte_valid_i && ready_q;
  assign byte_ready_o = ready_q;
  assign next_base    = base_q + OFF_W'(cnt_q) + OFF_W'(1);

  ild_opc_class i_cls (
    .op_i  (byte_i),
    .esc_i (state_q == ST_OP2),
    .cls_o (cls)
  );

  ild_addr_calc i_addr (
    .byte_i     (byte_i),
    .is_sib_i   (state_q == ST_SIB),
    .mod_i      (mod_q),
    .need_sib_o (need_sib),
    .disp_n_o   (disp_n)
  );

  always_comb begin
    state_d = state_q;
    mod_d   = mod_q;
    disp_d  = disp_q;
    sys_d   = sys_q;
    imm_d   = imm_q;
    fin     = 1'b0;
    fin_ud  = 1'b0;
    fin_gp  = 1'b0;
    fin_bad = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_OP, ST_OP2: begin
          sys_d = (cls == CL_SYS);
          imm_d = (cls == CL_GEN_I8);
          unique case (cls)
            CL_ESC:                   state_d = ST_OP2;
            CL_GEN, CL_GEN_I8, CL_SYS: state_d = ST_MODRM;
            default: begin
              fin    = 1'b1;
              fin_ud = 1'b1;
            end
          endcase
        end
        ST_MODRM: begin
          mod_d = byte_i[7:6];
          if (sys_q) begin
            // register form implied, mod only matters to the strict check
            fin     = 1'b1;
            fin_gp  = (cpl_i != 2'd0);
            fin_bad = strict_i && (byte_i[7:6] != 2'b11);
          end else if (need_sib) begin
            state_d = ST_SIB;
          end else if (disp_n != 3'd0) begin
            disp_d  = disp_n;
            state_d = ST_DISP;
          end else if (imm_q) begin
            state_d = ST_IMM;
          end else begin
            fin = 1'b1;
          end
        end
        ST_SIB: begin
          if (disp_n != 3'd0) begin
            disp_d  = disp_n;
            state_d = ST_DISP;
          end else if (imm_q) begin
            state_d = ST_IMM;
          end else begin
            fin = 1'b1;
          end
        end
        ST_DISP: begin
          disp_d = disp_q - 3'd1;
          if (disp_q == 3'd1) begin
            if (imm_q) state_d = ST_IMM;
            else       fin     = 1'b1;
          end
        end
        default: fin = 1'b1;
      endcase
      if (fin) state_d = ST_OP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OP;
      ready_q    <= 1'b0;
      cnt_q      <= '0;
      base_q     <= '0;
      mod_q      <= 2'b00;
      disp_q     <= 3'd0;
      sys_q      <= 1'b0;
      imm_q      <= 1'b0;
      done_o     <= 1'b0;
      len_o      <= '0;
      start_o    <= '0;
      next_o     <= '0;
      ud_o       <= 1'b0;
      gp_fault_o <= 1'b0;
      bad_enc_o  <= 1'b0;
    end else begin
      ready_q    <= 1'b1;
      state_q    <= state_d;
      mod_q      <= mod_d;
      disp_q     <= disp_d;
      sys_q      <= sys_d;
      imm_q      <= imm_d;
      done_o     <= fin;
      ud_o       <= fin_ud;
      gp_fault_o <= fin_gp;
      bad_enc_o  <= fin_bad;
      if (accept) cnt_q <= fin ? '0 : cnt_q + LEN_W'(1);
      if (fin) begin
        base_q  <= next_base;
        len_o   <= cnt_q + LEN_W'(1);
        start_o <= base_q;
        next_o  <= next_base;
      end
    end
  end

  logic unused_w;
  assign unused_w = ^CNT_W;
endmodule

// File: rtl/ild_checker.sv
module ild_checker #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_valid_i,
  input logic             byte_ready_o,
  input logic             done_o,
  input logic [LEN_W-1:0] len_o,
  input logic [OFF_W-1:0] start_o,
  input logic [OFF_W-1:0] next_o,
  input logic             ud_o,
  input logic             gp_fault_o,
  input logic             bad_enc_o
);
  logic [OFF_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chain_q <= '0;
    else if (done_o) chain_q <= next_o;
  end

  a_r10_next_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> next_o == start_o + OFF_W'(len_o));

  a_r10_chained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> start_o == chain_q);

  a_r11_done_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_valid_i && byte_ready_o));

  a_r2_len_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= LEN_W'(1)) && (len_o <= LEN_W'(8)));

  a_r6_sys_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (gp_fault_o || bad_enc_o)) |-> len_o == LEN_W'(3));

  a_r9_ud_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ud_o) |-> (len_o <= LEN_W'(2)) && !gp_fault_o && !bad_enc_o);

  a_r8_flags_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !ud_o && !gp_fault_o && !bad_enc_o);
endmodule

bind insn_len_decoder ild_checker #(.OFF_W(OFF_W), .LEN_W(LEN_W)) i_ild_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .done_o       (done_o),
  .len_o        (len_o),
  .start_o      (start_o),
  .next_o       (next_o),
  .ud_o         (ud_o),
  .gp_fault_o   (gp_fault_o),
  .bad_enc_o    (bad_enc_o)
);

// File: tb/test_insn_len_decoder.sv
module test_insn_len_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 8;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       byte_i = 8'h00;
  logic             byte_valid_i = 1'b0;
  logic             byte_ready_o;
  logic             strict_i = 1'b0;
  logic [1:0]       cpl_i = 2'd0;
  logic             done_o;
  logic [LEN_W-1:0] len_o;
  logic [OFF_W-1:0] start_o, next_o;
  logic             ud_o, gp_fault_o, bad_enc_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int m_pos = 0;
  logic [7:0] strm[$];

  // pending expectation for the next sample point
  bit e_done = 0;
  int e_len, e_start, e_next;
  bit e_ud, e_gp, e_bad;
  string e_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  insn_len_decoder #(.OFF_W(OFF_W), .LEN_W(LEN_W)) i_insn_len_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .strict_i(strict_i), .cpl_i(cpl_i),
    .done_o(done_o), .len_o(len_o), .start_o(start_o), .next_o(next_o),
    .ud_o(ud_o), .gp_fault_o(gp_fault_o), .bad_enc_o(bad_enc_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int addr_bytes(int p);
    int m, r, n;
    m = strm[p] >> 6;
    r = strm[p] & 7;
    n = 1;
    if (m == 3) return n;
    if (r == 4) begin
      n++;
      if (m == 0 && (strm[p+1] & 7) == 5) n += 4;
    end else if (m == 0 && r == 5) n += 4;
    if (m == 1) n += 1;
    if (m == 2) n += 4;
    return n;
  endfunction

  function automatic void ref_decode(input int p, output int len, output bit ud,
                                     output bit gp, output bit bad, output string tag);
    int b0;
    b0 = strm[p];
    ud = 0; gp = 0; bad = 0;
    if (b0 == 8'h0F) begin
      if (strm[p+1] >= 8'h20 && strm[p+1] <= 8'h23) begin
        len = 3;
        gp  = (cpl_i != 0);
        bad = strict_i && ((strm[p+2] >> 6) != 3);
        tag = gp ? "R8" : (bad ? "R7" : "R6");
      end else if (strm[p+1] == 8'hAF) begin
        len = 2 + addr_bytes(p + 2);
        tag = "R5";
      end else begin
        len = 2; ud = 1; tag = "R9";
      end
    end else if (b0 == 8'h01 || b0 == 8'h03 || b0 == 8'h89 || b0 == 8'h8B ||
                 b0 == 8'h8D || b0 == 8'h83) begin
      len = 1 + addr_bytes(p + 1) + ((b0 == 8'h83) ? 1 : 0);
      if (b0 == 8'h83) tag = "R4";
      else if ((strm[p+1] & 7) == 4 && (strm[p+1] >> 6) != 3) tag = "R3";
      else tag = "R2";
    end else begin
      len = 1; ud = 1; tag = "R9";
    end
  endfunction

  task automatic compare();
    if (e_done) begin
      check(e_tag, "done", done_o, 1);
      if (done_o) begin
        check(e_tag, "len", len_o, e_len);
        check("R10", "start", start_o, e_start);
        check("R10", "next", next_o, e_next);
        check(e_tag, "ud", ud_o, e_ud);
        check(e_tag, "gp", gp_fault_o, e_gp);
        check(e_tag, "bad_enc", bad_enc_o, e_bad);
      end
    end else begin
      check("R11", "done idle", done_o, 0);
    end
  endtask

  task automatic run_stream(bit strict, logic [1:0] cpl);
    int i, last, len;
    bit ud, gp, bad;
    string tag;
    i = 0;
    last = -1;
    strict_i = strict;
    cpl_i = cpl;
    while (i < strm.size()) begin
      @(negedge clk);
      compare();
      if ((cyc % 7) == 4) begin
        byte_valid_i = 1'b0;    // R11 stall cycle
        e_done = 0;
      end else begin
        if (i > last) begin
          ref_decode(i, len, ud, gp, bad, tag);
          last = i + len - 1;
        end
        byte_valid_i = 1'b1;
        byte_i = strm[i];
        if (i == last) begin
          e_done = 1; e_len = len; e_ud = ud; e_gp = gp; e_bad = bad; e_tag = tag;
          e_start = m_pos;
          m_pos = (m_pos + len) % (1 << OFF_W);
          e_next = m_pos;
        end else e_done = 0;
        i++;
      end
    end
    @(negedge clk);
    compare();
    byte_valid_i = 1'b0;
    e_done = 0;
    strm.delete();
  endtask

  task automatic push(input int b[]);
    foreach (b[k]) strm.push_back(8'(b[k]));
  endtask

  task automatic gen_random(int count);
    for (int k = 0; k < count; k++) begin
      int sel, mrm, m, r, nd;
      sel = $urandom % 5;
      if (sel == 4) begin
        push('{8'h0F, 8'h20 + ($urandom % 4), $urandom % 256});
      end else begin
        case (sel)
          0: strm.push_back(8'h89);
          1: strm.push_back(8'h83);
          2: push('{8'h0F, 8'hAF});
          default: strm.push_back(8'h8B);
        endcase
        mrm = $urandom % 256;
        strm.push_back(8'(mrm));
        m = mrm >> 6; r = mrm & 7; nd = 0;
        if (m != 3) begin
          if (r == 4) begin
            int s;
            s = $urandom % 256;
            strm.push_back(8'(s));
            if (m == 0 && (s & 7) == 5) nd = 4;
          end else if (m == 0 && r == 5) nd = 4;
          if (m == 1) nd = 1;
          if (m == 2) nd = 4;
        end
        for (int d = 0; d < nd; d++) strm.push_back(8'($urandom % 256));
        if (sel == 1) strm.push_back(8'($urandom % 256));
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    byte_valid_i = 1'b0;
    e_done = 0;
    m_pos = 0;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", done_o, 0);
    check("R1", "ready in reset", byte_ready_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", byte_ready_o, 1);
    check("R1", "done after reset", done_o, 0);
  endtask

  initial begin
    do_reset();
    // R2 / R3 / R4 / R5 / R6 / R9 mixed, no strictness, ring 0
    push('{8'h89, 8'hC3, 8'h8B, 8'h45, 8'h08, 8'h89, 8'h85, 0, 1, 0, 0});
    push('{8'h8B, 8'h05, 1, 2, 3, 4, 8'h8B, 8'h00});
    push('{8'h01, 8'h04, 8'h24, 8'h03, 8'h04, 8'h25, 9, 9, 9, 9});
    push('{8'h8D, 8'h44, 8'h24, 8'h10, 8'h83, 8'hC0, 8'h05});
    push('{8'h83, 8'h84, 8'h24, 1, 2, 3, 4, 8'h7F});
    push('{8'h0F, 8'hAF, 8'hC1, 8'h0F, 8'hAF, 8'h45, 8'hF8});
    push('{8'h0F, 8'h20, 8'h53, 8'hFF, 8'h0F, 8'h22, 8'hD8});
    push('{8'h0F, 8'h21, 8'h93, 8'h90, 8'h0F, 8'h0B, 8'hC3});
    run_stream(0, 2'd0);
    // R7 strict checking
    push('{8'h0F, 8'h20, 8'h53, 8'h0F, 8'h22, 8'hC3, 8'h0F, 8'h23, 8'h85});
    push('{8'h8B, 8'h45, 8'h08});
    run_stream(1, 2'd0);
    // R8 privilege
    push('{8'h0F, 8'h20, 8'hC0, 8'h0F, 8'h21, 8'h45, 8'h89, 8'hC3});
    run_stream(0, 2'd3);
    push('{8'h0F, 8'h22, 8'h4A, 8'h0F, 8'h20, 8'hE0, 8'hF4});
    run_stream(1, 2'd1);
    // R10 offset wrap over a long run
    gen_random(80);
    run_stream(0, 2'd0);
    gen_random(20);
    run_stream(1, 2'd2);
    // R1 restart after a reset mid-run
    do_reset();
    push('{8'h0F, 8'h20, 8'h53, 8'hFF, 8'h89, 8'h45, 8'h01});
    run_stream(0, 2'd0);
    repeat (2) @(negedge clk);
    check("R11", "quiet tail", done_o, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule